// File: doc/BRIEF.md
# Multi-Class Register Rename Table

This block keeps the architectural-to-physical register mapping for an out-of-order core. Integer, floating-point and condition-code registers each have their own map and their own FIFO of free physical registers. Callers present a unified architectural index. The block splits that index into a register class and an index relative to that class, and serves the request from the matching class map.

A rename request pops the head of the class free FIFO, returns it as the new physical register together with the mapping it displaces, and installs it at the next clock edge. Lookups are purely combinational. A direct entry write restores older mappings after a squash. A release port returns retired physical registers to the free FIFO of the class they belong to.

Miscellaneous registers are never renamed. They map to a fixed physical index above the renamable range. Each class can also nominate one read-only zero register that renames leave untouched.

Top module: `rn_rename_table`

## Requirements
- R1: After reset, architectural register i of each class maps to physical register base+i. The bases are 0 for integer, INT_PHYS for floating point and INT_PHYS+FP_PHYS for condition codes. Each class free FIFO holds the remaining physical registers of that class in ascending order.
- R2: A rename of a renamable register returns the free FIFO head as the new register and the current mapping as the previous register, in the same cycle. It pops the head, and the map holds the new register after the next rising clock edge.
- R3: A rename aimed at a class zero register (integer relative index INT_ZERO by default 0; any index ≥ the class size disables it) returns the current mapping as both new and previous, pops nothing, changes no map entry and never stalls.
- R4: The lookup port returns the current physical register of any architectural index combinationally and changes no state.
- R5: A direct entry write replaces one mapping at the next edge. When it targets the same entry as a rename in the same cycle, the written value is the one kept.
- R6: Unified indices form contiguous ranges in this order: integer [0, INT_ARCH), floating point, condition code, then miscellaneous, each range as wide as its parameter.
- R7: A miscellaneous register with relative index r has physical index r + INT_PHYS + FP_PHYS + CC_PHYS. Renaming it returns that value as both new and previous and changes no state.
- R8: A rename aimed at a class whose free FIFO is empty raises the stall output in the same cycle and leaves all maps and FIFOs unchanged.
- R9: A valid release pushes the physical index onto the tail of the FIFO of the class whose physical range contains it. Indices at or above the total physical register count are ignored.
- R10: The free-count output equals the smaller of the integer and floating-point free FIFO occupancies. It is independent of the condition-code FIFO.
- R11: Free registers are handed out in first-in first-out order, so a released register is reused only after every register already queued ahead of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request |
| ren_arch | input | AW | Unified architectural index to rename |
| ren_new | output | PW | Newly assigned physical register |
| ren_prev | output | PW | Physical register being replaced |
| ren_stall | output | 1 | Rename cannot proceed: class free FIFO empty |
| lk_arch | input | AW | Unified architectural index to look up |
| lk_phys | output | PW | Physical register currently mapped |
| wr_valid | input | 1 | Direct entry write |
| wr_arch | input | AW | Unified architectural index to overwrite |
| wr_phys | input | PW | Physical register to install |
| rel_valid | input | 1 | Physical register release |
| rel_phys | input | PW | Physical register being released |
| free_count | output | CW | Minimum of integer and floating-point free counts |

## Verification
The bench checks the boundaries of the unified index decode. A one-off error there would route a floating-point or miscellaneous index into the wrong map and return a neighbour's register.

It renames the integer zero register, including when the integer free list is empty. A design that pops or stalls there would lose a register or block an instruction that needs none.

It drains the condition-code and integer free lists to empty to check the stall and confirm that no state moves. A wrong design would hand out a stale head or corrupt the map.

It also issues a rename and a squash write to the same entry in one cycle, and releases registers both inside and outside the physical range. It then confirms the exact reuse order that first-in first-out allocation demands.

// File: rtl/rn_pkg.sv
package rn_pkg;

    typedef enum logic [1:0] {
        RC_INT  = 2'd0,
        RC_FP   = 2'd1,
        RC_CC   = 2'd2,
        RC_MISC = 2'd3
    } reg_class_e;

    localparam int NUM_RENAMED = 3;

endpackage

// File: rtl/rn_free_fifo.sv
module rn_free_fifo #(
    parameter int DEPTH     = 16,
    parameter int INIT_FILL = 8,
    parameter int FIRST_REG = 8,
    parameter int PW        = 6,
    parameter int CW        = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [PW-1:0] push_reg,
    output logic [PW-1:0] head,
    output logic [CW-1:0] count
);

    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PW-1:0]   slots [DEPTH];
    logic [PTRW-1:0] rd_ptr;
    logic [PTRW-1:0] wr_ptr;
    logic            push_ok;

    assign push_ok = push && ((count < CW'(DEPTH)) || pop);
    assign head    = slots[rd_ptr];

    function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
        return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= (i < INIT_FILL) ? PW'(FIRST_REG + i) : '0;
            end
            rd_ptr <= '0;
            wr_ptr <= PTRW'(INIT_FILL % DEPTH);
            count  <= CW'(INIT_FILL);
        end else begin
            if (push_ok) begin
                slots[wr_ptr] <= push_reg;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            if (push_ok && !pop) begin
                count <= count + 1'b1;
            end else if (pop && !push_ok) begin
                count <= count - 1'b1;
            end
        end
    end

    // R8: the table must never pop an empty free list
    assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));

    // R9: an accepted release grows the list by exactly one
    assert_release_counts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && !pop) |=> (count == $past(count) + 1'b1));

    // R2: a pop without a release shrinks the list by exactly one
    assert_pop_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push_ok) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/rn_class_map.sv
module rn_class_map #(
    parameter int ARCH = 8,
    parameter int BASE = 0,
    parameter int ZERO = 0,
    parameter int AW   = 5,
    parameter int PW   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_idx,
    output logic [PW-1:0] rd_phys,
    input  logic [AW-1:0] ren_idx,
    output logic [PW-1:0] ren_cur,
    input  logic          ren_we,
    input  logic [PW-1:0] ren_phys,
    input  logic          wr_we,
    input  logic [AW-1:0] wr_idx,
    input  logic [PW-1:0] wr_phys
);

    localparam int IW = (ARCH > 1) ? $clog2(ARCH) : 1;

    logic [PW-1:0] entry [ARCH];

    assign rd_phys = (rd_idx < AW'(ARCH))  ? entry[rd_idx[IW-1:0]]  : '0;
    assign ren_cur = (ren_idx < AW'(ARCH)) ? entry[ren_idx[IW-1:0]] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH; i++) begin
                entry[i] <= PW'(BASE + i);
            end
        end else begin
            if (ren_we && (ren_idx < AW'(ARCH))) begin
                entry[ren_idx[IW-1:0]] <= ren_phys;
            end
            // squash restore is applied last so it wins on the same entry
            if (wr_we && (wr_idx < AW'(ARCH))) begin
                entry[wr_idx[IW-1:0]] <= wr_phys;
            end
        end
    end

    // R3: the zero register is never written by a rename
    assert_zero_readonly_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ren_we |-> (ren_idx != AW'(ZERO)));

    // R2: a rename installs the popped register at the next edge
    assert_rename_installs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_we && !(wr_we && wr_idx == ren_idx)) |=> (ren_cur == $past(ren_phys)) || (ren_idx != $past(ren_idx)));

    // R5: a direct write is what the entry holds afterwards
    assert_write_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_we && wr_idx < AW'(ARCH)) |=> (rd_phys == $past(wr_phys)) || (rd_idx != $past(wr_idx)));

endmodule

// File: rtl/rn_rename_table.sv
module rn_rename_table
    import rn_pkg::*;
#(
    parameter int INT_ARCH  = 8,
    parameter int FP_ARCH   = 8,
    parameter int CC_ARCH   = 4,
    parameter int MISC_ARCH = 4,
    parameter int INT_PHYS  = 16,
    parameter int FP_PHYS   = 16,
    parameter int CC_PHYS   = 8,
    parameter int INT_ZERO  = 0,
    parameter int FP_ZERO   = FP_ARCH,
    parameter int CC_ZERO   = CC_ARCH,
    parameter int FP_LO     = INT_ARCH,
    parameter int CC_LO     = FP_LO + FP_ARCH,
    parameter int MISC_LO   = CC_LO + CC_ARCH,
    parameter int ARCH_ALL  = MISC_LO + MISC_ARCH,
    parameter int PHYS_ALL  = INT_PHYS + FP_PHYS + CC_PHYS,
    parameter int AW        = $clog2(ARCH_ALL),
    parameter int PW        = $clog2(PHYS_ALL + MISC_ARCH),
    parameter int CW        = $clog2(((INT_PHYS > FP_PHYS) ? INT_PHYS : FP_PHYS) + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid,
    input  logic [AW-1:0] ren_arch,
    output logic [PW-1:0] ren_new,
    output logic [PW-1:0] ren_prev,
    output logic          ren_stall,
    input  logic [AW-1:0] lk_arch,
    output logic [PW-1:0] lk_phys,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_arch,
    input  logic [PW-1:0] wr_phys,
    input  logic          rel_valid,
    input  logic [PW-1:0] rel_phys,
    output logic [CW-1:0] free_count
);

    localparam int ARCH_N [NUM_RENAMED] = '{INT_ARCH, FP_ARCH, CC_ARCH};
    localparam int PHYS_N [NUM_RENAMED] = '{INT_PHYS, FP_PHYS, CC_PHYS};
    localparam int BASE_N [NUM_RENAMED] = '{0, INT_PHYS, INT_PHYS + FP_PHYS};
    localparam int ZERO_N [NUM_RENAMED] = '{INT_ZERO, FP_ZERO, CC_ZERO};

    function automatic reg_class_e class_of(input logic [AW-1:0] idx);
        if (idx < AW'(FP_LO))        return RC_INT;
        else if (idx < AW'(CC_LO))   return RC_FP;
        else if (idx < AW'(MISC_LO)) return RC_CC;
        else                         return RC_MISC;
    endfunction

    function automatic logic [AW-1:0] rel_of(input logic [AW-1:0] idx);
        if (idx < AW'(FP_LO))        return idx;
        else if (idx < AW'(CC_LO))   return idx - AW'(FP_LO);
        else if (idx < AW'(MISC_LO)) return idx - AW'(CC_LO);
        else                         return idx - AW'(MISC_LO);
    endfunction

    reg_class_e    ren_cls, lk_cls, wr_cls;
    logic [AW-1:0] ren_rel, lk_rel, wr_rel;

    assign ren_cls = class_of(ren_arch);
    assign ren_rel = rel_of(ren_arch);
    assign lk_cls  = class_of(lk_arch);
    assign lk_rel  = rel_of(lk_arch);
    assign wr_cls  = class_of(wr_arch);
    assign wr_rel  = rel_of(wr_arch);

    logic [PW-1:0] map_rd   [NUM_RENAMED];
    logic [PW-1:0] map_cur  [NUM_RENAMED];
    logic [PW-1:0] fifo_hd  [NUM_RENAMED];
    logic [CW-1:0] fifo_cnt [NUM_RENAMED];
    logic [NUM_RENAMED-1:0] cls_hit, cls_zero, cls_pop, cls_wr, cls_push;

    for (genvar c = 0; c < NUM_RENAMED; c++) begin : g_class
        assign cls_hit[c]  = ren_valid && (ren_cls == reg_class_e'(c));
        assign cls_zero[c] = (ren_rel == AW'(ZERO_N[c]));
        assign cls_pop[c]  = cls_hit[c] && !cls_zero[c] && (fifo_cnt[c] != '0);
        assign cls_wr[c]   = wr_valid && (wr_cls == reg_class_e'(c));
        assign cls_push[c] = rel_valid && (rel_phys >= PW'(BASE_N[c]))
                             && (rel_phys < PW'(BASE_N[c] + PHYS_N[c]));

        rn_class_map #(
            .ARCH (ARCH_N[c]),
            .BASE (BASE_N[c]),
            .ZERO (ZERO_N[c]),
            .AW   (AW),
            .PW   (PW)
        ) map_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (lk_rel),
            .rd_phys  (map_rd[c]),
            .ren_idx  (ren_rel),
            .ren_cur  (map_cur[c]),
            .ren_we   (cls_pop[c]),
            .ren_phys (fifo_hd[c]),
            .wr_we    (cls_wr[c]),
            .wr_idx   (wr_rel),
            .wr_phys  (wr_phys)
        );

        rn_free_fifo #(
            .DEPTH     (PHYS_N[c]),
            .INIT_FILL (PHYS_N[c] - ARCH_N[c]),
            .FIRST_REG (BASE_N[c] + ARCH_N[c]),
            .PW        (PW),
            .CW        (CW)
        ) fifo_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .pop      (cls_pop[c]),
            .push     (cls_push[c]),
            .push_reg (rel_phys),
            .head     (fifo_hd[c]),
            .count    (fifo_cnt[c])
        );
    end

    // rename response
    always_comb begin
        ren_new   = PW'(ren_rel) + PW'(PHYS_ALL);
        ren_prev  = PW'(ren_rel) + PW'(PHYS_ALL);
        ren_stall = 1'b0;
        for (int c = 0; c < NUM_RENAMED; c++) begin
            if (ren_cls == reg_class_e'(c)) begin
                ren_prev = map_cur[c];
                ren_new  = cls_zero[c] ? map_cur[c] : fifo_hd[c];
                ren_stall = ren_valid && !cls_zero[c] && (fifo_cnt[c] == '0);
            end
        end
    end

    // lookup response
    always_comb begin
        unique case (lk_cls)
            RC_INT:  lk_phys = map_rd[0];
            RC_FP:   lk_phys = map_rd[1];
            RC_CC:   lk_phys = map_rd[2];
            RC_MISC: lk_phys = PW'(lk_rel) + PW'(PHYS_ALL);
            default: lk_phys = '0;
        endcase
    end

    assign free_count = (fifo_cnt[0] < fifo_cnt[1]) ? fifo_cnt[0] : fifo_cnt[1];

    // R7: miscellaneous renames hand back one fixed register above the renamable range
    assert_misc_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_cls == RC_MISC) |-> (ren_new == ren_prev && ren_new >= PW'(PHYS_ALL) && !ren_stall));

    // R8: a stalled rename pops no free list
    assert_stall_no_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ren_stall |-> (cls_pop == '0));

    // R10: reported count never exceeds either class occupancy
    assert_free_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (free_count <= fifo_cnt[0]) && (free_count <= fifo_cnt[1]));

endmodule

// File: tb/rn_rename_table_tb_top.sv
module rn_rename_table_tb_top;

    localparam int AW = 5;
    localparam int PW = 6;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ren_valid = 1'b0;
    logic [AW-1:0] ren_arch = '0;
    logic [PW-1:0] ren_new, ren_prev;
    logic          ren_stall;
    logic [AW-1:0] lk_arch = '0;
    logic [PW-1:0] lk_phys;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_arch = '0;
    logic [PW-1:0] wr_phys = '0;
    logic          rel_valid = 1'b0;
    logic [PW-1:0] rel_phys = '0;
    logic [CW-1:0] free_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rn_rename_table dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ren_valid  (ren_valid),
        .ren_arch   (ren_arch),
        .ren_new    (ren_new),
        .ren_prev   (ren_prev),
        .ren_stall  (ren_stall),
        .lk_arch    (lk_arch),
        .lk_phys    (lk_phys),
        .wr_valid   (wr_valid),
        .wr_arch    (wr_arch),
        .wr_phys    (wr_phys),
        .rel_valid  (rel_valid),
        .rel_phys   (rel_phys),
        .free_count (free_count)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic look(input string req, input int arch, input int exp);
        lk_arch = AW'(arch);
        #1;
        check(req, $sformatf("lookup %0d", arch), int'(lk_phys), exp);
    endtask

    // drive one rename over one clock edge; checks the same-cycle response
    task automatic rename(input string req, input int arch, input int exp_new,
                          input int exp_prev, input int exp_stall);
        @(negedge clk);
        ren_valid = 1'b1;
        ren_arch  = AW'(arch);
        #1;
        check(req, $sformatf("stall arch %0d", arch), int'(ren_stall), exp_stall);
        if (exp_stall == 0) begin
            check(req, $sformatf("new arch %0d", arch), int'(ren_new), exp_new);
            check(req, $sformatf("prev arch %0d", arch), int'(ren_prev), exp_prev);
        end
        @(negedge clk);
        ren_valid = 1'b0;
    endtask

    task automatic release_reg(input int phys);
        @(negedge clk);
        rel_valid = 1'b1;
        rel_phys  = PW'(phys);
        @(negedge clk);
        rel_valid = 1'b0;
    endtask

    task automatic t_reset;
        look("R1", 0, 0);
        look("R1", 7, 7);
        look("R6", 8, 16);
        look("R6", 15, 23);
        look("R6", 16, 32);
        look("R1", 19, 35);
        look("R7", 20, 40);
        look("R7", 23, 43);
        check("R10", "free count after reset", int'(free_count), 8);
    endtask

    task automatic t_basic_rename;
        rename("R2", 3, 8, 3, 0);
        look("R2", 3, 8);
        check("R10", "free count int 7 fp 8", int'(free_count), 7);
        rename("R6", 9, 24, 17, 0);
        rename("R6", 10, 25, 18, 0);
        look("R4", 10, 25);
        look("R4", 10, 25);
        check("R10", "free count int 7 fp 6", int'(free_count), 6);
    endtask

    task automatic t_zero;
        rename("R3", 0, 0, 0, 0);
        look("R3", 0, 0);
        check("R3", "free count after zero rename", int'(free_count), 6);
        rename("R3", 4, 9, 4, 0);
    endtask

    task automatic t_misc;
        rename("R7", 21, 41, 41, 0);
        look("R7", 21, 41);
        check("R7", "free count after misc rename", int'(free_count), 6);
    endtask

    task automatic t_set_entry;
        @(negedge clk);
        wr_valid = 1'b1; wr_arch = AW'(3); wr_phys = PW'(3);
        @(negedge clk);
        wr_valid = 1'b0;
        look("R5", 3, 3);
        // same cycle: rename and restore of arch 5
        @(negedge clk);
        ren_valid = 1'b1; ren_arch = AW'(5);
        wr_valid  = 1'b1; wr_arch = AW'(5); wr_phys = PW'(5);
        #1;
        check("R5", "collide new", int'(ren_new), 10);
        check("R5", "collide prev", int'(ren_prev), 5);
        @(negedge clk);
        ren_valid = 1'b0; wr_valid = 1'b0;
        look("R5", 5, 5);
        check("R10", "free count int 5 fp 6", int'(free_count), 5);
    endtask

    task automatic t_release;
        release_reg(8);
        check("R9", "free count after int release", int'(free_count), 6);
        release_reg(45);
        release_reg(40);
        check("R9", "free count after out-of-range release", int'(free_count), 6);
    endtask

    task automatic t_cc_stall;
        rename("R2", 16, 36, 32, 0);
        rename("R2", 16, 37, 36, 0);
        rename("R2", 16, 38, 37, 0);
        rename("R2", 16, 39, 38, 0);
        rename("R8", 16, 0, 0, 1);
        look("R8", 16, 39);
        check("R10", "free count ignores cc", int'(free_count), 6);
        release_reg(32);
        rename("R9", 17, 32, 33, 0);
    endtask

    task automatic t_int_order;
        int expv [6] = '{11, 12, 13, 14, 15, 8};
        int prev = 6;
        for (int k = 0; k < 6; k++) begin
            rename("R11", 6, expv[k], prev, 0);
            prev = expv[k];
        end
        check("R10", "free count int empty", int'(free_count), 0);
        rename("R8", 6, 0, 0, 1);
        look("R8", 6, 8);
        rename("R3", 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_rename();
        t_zero();
        t_misc();
        t_set_entry();
        t_release();
        t_cc_stall();
        t_int_order();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule